// File: doc/BRIEF.md
# USB Host High-Speed Test Mode Controller

This block holds the high-speed electrical test mode of each USB 2.0 host port. Software writes an 8-bit control register for each port. A mode is accepted only when four things hold: the port's host state allows it, every transfer and support channel of that port is stopped, the automatic-mode cancel status is clear, and the write carries the enable bit together with exactly one mode bit. Once a mode is accepted, the block drives one one-hot select line toward the PHY and link logic: constant J, constant K, SE0 with NAK receive, test packet, or forced enable with SOF and disconnect watch.

The mode stays active until software writes 00h to the register. That write clears the mode and raises a one-cycle request telling the host state machine to return to IDLE. To change modes, software must first exit with 00h. The register of each port sits at offset 164h above the port's base. Port bases are spaced 200h apart, so port 0 is at 164h and port 1 at 364h.

Top module: `usb_host_testmode_ctrl`

## Requirements
- R1: After synchronous reset, every mode select output and every idle request is 0, and both port registers read 00h.
- R2: A port's register is written and read only at its own address: 164h for port 0 and 364h for port 1. Any other address writes nothing and reads 00h.
- R3: An accepted write selects a mode from the bit set among bits 4..0: bit 4 is force-enable with SOF, bit 3 is SE0_NAK, bit 2 is J, bit 1 is K, and bit 0 is test packet. The matching select output is high from the clock edge that takes the write. At most one select output per port is high at any time.
- R4: A nonzero write is ignored if bit 7 (the enable) is clear, or if zero mode bits are set, or if more than one mode bit is set.
- R5: Entry is accepted only while the port's 3-bit host state is 1 (WAIT_CONNECT), 2 (DISABLED) or 3 (SUSPEND). States 0 (IDLE) and 4..7 reject the write.
- R6: Entry is rejected while any channel transfer-go bit of the port is 1, while any support-go bit of the port is 1, or while the auto-mode-cancel status of the port is 1.
- R7: While a mode is active, it holds regardless of host state or precondition inputs. Every nonzero write is ignored, including one that would select a different mode.
- R8: A 00h write clears the active mode. On the same edge, the idle request rises for exactly one cycle. A 00h write when no mode is active raises no request.
- R9: Readback is bit 7 = 1 while a mode is active, bits 6..5 = 0, and bits 4..0 = the active mode. Reserved bits written as 1 do not prevent entry and are not stored.
- R10: The two ports are independent. A write or input to one port never changes the other port's mode or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| host_state | input | 6 | Host port state, 3 bits per port |
| chan_go | input | 12 | Channel transfer-go flags, 6 per port |
| support_go | input | 4 | Support-go flags, 2 per port |
| auto_cancel | input | 2 | Auto-mode-cancel status, 1 per port |
| tm_force_sof | output | 2 | Force-enable with SOF mode select, per port |
| tm_se0_nak | output | 2 | SE0_NAK mode select, per port |
| tm_j | output | 2 | Constant J mode select, per port |
| tm_k | output | 2 | Constant K mode select, per port |
| tm_packet | output | 2 | Test packet mode select, per port |
| idle_req | output | 2 | One-cycle request to return the host state to IDLE, per port |

## Verification
The bench targets several corner cases:
- A direct switch from one mode to another without a 00h exit. A design that allowed it would drive a new select line while the old mode was still nominally in force.
- A 00h write with no mode active. A faulty design would send a spurious IDLE request and knock a running host state machine back to IDLE.
- Writes that carry the enable bit with zero or two mode bits, and writes made in host states or precondition combinations just outside the allowed set. A design that got these wrong would assert several select lines at once, or enter a test mode while a channel was still running.
- Writes at neighbouring addresses and writes to the other port. A design that mishandled these would reveal a decoder that matches too broadly or cross-couples the ports.

// File: rtl/usb_tm_pkg.sv
// Package usb_tm_pkg
// Shared encodings for the host test mode controller: host port state codes
// and the bit positions of the per-port test mode control register.
// Assumes the host state is delivered as a 3-bit code per port.
package usb_tm_pkg;

    localparam int HS_W   = 3;
    localparam int MODE_W = 5;
    localparam int REG_W  = 8;

    typedef enum logic [HS_W-1:0] {
        HS_IDLE      = 3'd0,
        HS_WAIT_CONN = 3'd1,
        HS_DISABLED  = 3'd2,
        HS_SUSPEND   = 3'd3,
        HS_RESUME    = 3'd4,
        HS_OPER      = 3'd5,
        HS_BUS_RST   = 3'd6,
        HS_OTHER     = 3'd7
    } host_state_e;

    // Register bit positions; software and link logic both decode these
    localparam int BIT_ENABLE = 7;
    localparam int BIT_FORCE  = 4;
    localparam int BIT_SE0NAK = 3;
    localparam int BIT_J      = 2;
    localparam int BIT_K      = 1;
    localparam int BIT_PACKET = 0;

endpackage

// File: rtl/tm_addr_dec.sv
// Module tm_addr_dec
// Decodes the register address into one select line per port. Port p owns
// the address p*STEP + OFS. Assumes byte addressing with no aliasing.
module tm_addr_dec #(
    parameter int ADDR_W    = 10,
    parameter int NUM_PORTS = 2,
    parameter int STEP      = 512,
    parameter int OFS       = 356
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PORTS-1:0] sel
);

    // One exact-match comparator per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
        localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(p * STEP + OFS);
        assign sel[p] = (addr == PORT_ADDR);
    end

endmodule

// File: rtl/tm_entry_gate.sv
// Module tm_entry_gate
// Reports whether a port may enter a test mode right now: the host state
// must be WAIT_CONNECT, DISABLED or SUSPEND, every channel and support go
// flag must be low, and the auto-mode-cancel status must be low.
// Purely combinational; it says nothing about the write data.
module tm_entry_gate
    import usb_tm_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int NUM_SUP = 2
) (
    input  logic [HS_W-1:0]    host_state,
    input  logic [NUM_CH-1:0]  chan_go,
    input  logic [NUM_SUP-1:0] support_go,
    input  logic               auto_cancel,
    output logic               entry_ok
);

    logic state_ok;

    // Host states in which a test mode may begin
    always_comb begin
        case (host_state_e'(host_state))
            HS_WAIT_CONN, HS_DISABLED, HS_SUSPEND: state_ok = 1'b1;
            default:                               state_ok = 1'b0;
        endcase
    end

    // All channel-stop preconditions combined with the state check
    assign entry_ok = state_ok && !(|chan_go) && !(|support_go) && !auto_cancel;

endmodule

// File: rtl/tm_port_ctl.sv
// Module tm_port_ctl
// Holds the test mode of one host port. A write enters a mode only when no
// mode is active, the enable bit is set with exactly one mode bit, and the
// entry gate agrees. A 00h write clears the mode and pulses idle_req once.
// Any other write is dropped. Assumes wr is already qualified by the address.
module tm_port_ctl
    import usb_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              entry_ok,
    output logic [MODE_W-1:0] mode,
    output logic              idle_req,
    output logic [REG_W-1:0]  rd_val
);

    logic [MODE_W-1:0] sel_bits;
    logic              single_sel;
    logic              is_zero_wr;
    logic              accept;

    // Classify the write data
    always_comb begin
        sel_bits   = wdata[MODE_W-1:0];
        single_sel = (sel_bits != '0) && ((sel_bits & (sel_bits - 1'b1)) == '0);
        is_zero_wr = (wdata == '0);
        accept     = wr && (mode == '0) && wdata[BIT_ENABLE] && single_sel && entry_ok;
    end

    // Mode register and exit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            idle_req <= 1'b0;
        end else begin
            idle_req <= 1'b0;
            if (wr && is_zero_wr) begin
                mode     <= '0;
                idle_req <= (mode != '0);
            end else if (accept) begin
                mode <= sel_bits;
            end
        end
    end

    // Readback: enable reflects an active mode, reserved bits read zero
    assign rd_val = {(mode != '0), 2'b00, mode};

    a_r3_onehot_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode));

    a_r6_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|mode) |-> $past(entry_ok && wr && wdata[BIT_ENABLE]));

    a_r7_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != '0) |=> (mode == $past(mode)) || (mode == '0));

    a_r8_req_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> (mode == '0) && ($past(mode) != '0));

    a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> !idle_req);

endmodule

// File: rtl/usb_host_testmode_ctrl.sv
// Module usb_host_testmode_ctrl
// Top of the host high-speed test mode controller. It decodes one 8-bit
// control register per port, gates entry per port on host state and
// channel-stop flags, and fans each port's mode out to one-hot select lines.
// Assumes flat per-port input vectors, with port 0 in the low slice.
module usb_host_testmode_ctrl
    import usb_tm_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_PORTS = 2,
    parameter int NUM_CH    = 6,
    parameter int NUM_SUP   = 2,
    parameter int PORT_STEP = 512,
    parameter int REG_OFS   = 356
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    input  logic [NUM_PORTS*HS_W-1:0]    host_state,
    input  logic [NUM_PORTS*NUM_CH-1:0]  chan_go,
    input  logic [NUM_PORTS*NUM_SUP-1:0] support_go,
    input  logic [NUM_PORTS-1:0]         auto_cancel,
    output logic [NUM_PORTS-1:0]         tm_force_sof,
    output logic [NUM_PORTS-1:0]         tm_se0_nak,
    output logic [NUM_PORTS-1:0]         tm_j,
    output logic [NUM_PORTS-1:0]         tm_k,
    output logic [NUM_PORTS-1:0]         tm_packet,
    output logic [NUM_PORTS-1:0]         idle_req
);

    logic [NUM_PORTS-1:0] port_sel;
    logic [NUM_PORTS-1:0] port_ok;
    logic [MODE_W-1:0]    port_mode [NUM_PORTS];
    logic [REG_W-1:0]     port_rd   [NUM_PORTS];

    tm_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .STEP      (PORT_STEP),
        .OFS       (REG_OFS)
    ) u_dec (
        .addr (addr),
        .sel  (port_sel)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tm_entry_gate #(
            .NUM_CH  (NUM_CH),
            .NUM_SUP (NUM_SUP)
        ) u_gate (
            .host_state  (host_state[p*HS_W +: HS_W]),
            .chan_go     (chan_go[p*NUM_CH +: NUM_CH]),
            .support_go  (support_go[p*NUM_SUP +: NUM_SUP]),
            .auto_cancel (auto_cancel[p]),
            .entry_ok    (port_ok[p])
        );

        tm_port_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_en && port_sel[p]),
            .wdata    (wdata),
            .entry_ok (port_ok[p]),
            .mode     (port_mode[p]),
            .idle_req (idle_req[p]),
            .rd_val   (port_rd[p])
        );

        // Fan the stored mode out to the select lines
        assign tm_force_sof[p] = port_mode[p][BIT_FORCE];
        assign tm_se0_nak[p]   = port_mode[p][BIT_SE0NAK];
        assign tm_j[p]         = port_mode[p][BIT_J];
        assign tm_k[p]         = port_mode[p][BIT_K];
        assign tm_packet[p]    = port_mode[p][BIT_PACKET];
    end

    // Read mux: the addressed port's register, or zero when nothing matches
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_sel[p]) rdata = port_rd[p];
        end
    end

    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel == '0) |-> (rdata == '0));

    a_r10_single_port_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));

endmodule

// File: tb/usb_host_testmode_ctrl_tb.sv
// Bench for usb_host_testmode_ctrl: directed corner cases followed by
// seeded random traffic, all checked against a reference model kept here.
module usb_host_testmode_ctrl_tb;

    localparam int NP = 2;
    localparam logic [9:0] A0 = 10'h164;
    localparam logic [9:0] A1 = 10'h364;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [5:0]  host_state = '0;
    logic [11:0] chan_go = '0;
    logic [3:0]  support_go = '0;
    logic [1:0]  auto_cancel = '0;
    logic [1:0]  tm_force_sof, tm_se0_nak, tm_j, tm_k, tm_packet, idle_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cyc = 0;

    logic [4:0] m_mode [NP];
    logic       m_req  [NP];

    usb_host_testmode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .host_state(host_state), .chan_go(chan_go),
        .support_go(support_go), .auto_cancel(auto_cancel),
        .tm_force_sof(tm_force_sof), .tm_se0_nak(tm_se0_nak), .tm_j(tm_j),
        .tm_k(tm_k), .tm_packet(tm_packet), .idle_req(idle_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit gate_ok(input int p);
        logic [2:0] hs;
        hs = host_state[p*3 +: 3];
        return (hs >= 3'd1 && hs <= 3'd3) && (chan_go[p*6 +: 6] == '0) &&
               (support_go[p*2 +: 2] == '0) && !auto_cancel[p];
    endfunction

    function automatic bit one_bit(input logic [4:0] v);
        return (v != '0) && ((v & (v - 5'd1)) == '0);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [9:0] a);
        if (a == A0) return {(m_mode[0] != '0), 2'b00, m_mode[0]};
        if (a == A1) return {(m_mode[1] != '0), 2'b00, m_mode[1]};
        return 8'h00;
    endfunction

    function automatic logic [4:0] dut_mode(input int p);
        return {tm_force_sof[p], tm_se0_nak[p], tm_j[p], tm_k[p], tm_packet[p]};
    endfunction

    // Update the reference model for the write seen at this edge
    task automatic model_edge();
        for (int p = 0; p < NP; p++) begin
            m_req[p] = 1'b0;
            if (wr_en && addr == (p == 0 ? A0 : A1)) begin
                if (wdata == 8'h00) begin
                    m_req[p]  = (m_mode[p] != '0);
                    m_mode[p] = '0;
                end else if (m_mode[p] == '0 && wdata[7] && one_bit(wdata[4:0]) && gate_ok(p)) begin
                    m_mode[p] = wdata[4:0];
                end
            end
        end
    endtask

    // Drive one cycle at the falling edge, then compare after the rising edge
    task automatic step(input logic w, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        #1;
        for (int p = 0; p < NP; p++) begin
            chk("R3 mode select", dut_mode(p), m_mode[p]);
            chk("R8 idle request", idle_req[p], m_req[p]);
        end
        chk("R9 readback", rdata, exp_rd(addr));
    endtask

    initial begin
        void'($urandom(32'h5eed_0071));
        m_mode[0] = '0; m_mode[1] = '0; m_req[0] = 0; m_req[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        #1;
        chk("R1 selects", {tm_force_sof, tm_se0_nak, tm_j, tm_k, tm_packet, idle_req}, 0);
        addr = A0; #1; chk("R1 read port0", rdata, 8'h00);
        addr = A1; #1; chk("R1 read port1", rdata, 8'h00);

        // Port 0 in WAIT_CONNECT, port 1 in IDLE
        host_state = {3'd0, 3'd1};
        step(1, A0, 8'h84);
        chk("R3 J entered", tm_j[0], 1);
        chk("R9 read 84h", rdata, 8'h84);
        chk("R10 port1 untouched", dut_mode(1), 5'h00);
        step(1, A0, 8'h82);
        chk("R7 switch ignored", dut_mode(0), 5'b00100);
        host_state[2:0] = 3'd5;
        step(1, A0, 8'h84);
        chk("R7 hold across state", tm_j[0], 1);
        step(1, A0, 8'h00);
        chk("R8 exit pulse", idle_req[0], 1);
        chk("R8 mode cleared", dut_mode(0), 5'h00);
        step(0, A0, 8'h00);
        chk("R8 pulse single", idle_req[0], 0);
        step(1, A0, 8'h00);
        chk("R8 no pulse when idle", idle_req[0], 0);

        // R5 / R6 on port 1
        step(1, A1, 8'h81);
        chk("R5 IDLE rejects", tm_packet[1], 0);
        host_state[5:3] = 3'd4;
        step(1, A1, 8'h81);
        chk("R5 state 4 rejects", tm_packet[1], 0);
        host_state[5:3] = 3'd3;
        auto_cancel[1] = 1'b1;
        step(1, A1, 8'h81);
        chk("R6 auto cancel rejects", tm_packet[1], 0);
        auto_cancel[1] = 1'b0; chan_go[11] = 1'b1;
        step(1, A1, 8'h81);
        chk("R6 chan go rejects", tm_packet[1], 0);
        chan_go[11] = 1'b0; support_go[2] = 1'b1;
        step(1, A1, 8'h81);
        chk("R6 support go rejects", tm_packet[1], 0);
        support_go[2] = 1'b0;
        step(1, A1, 8'h81);
        chk("R3 packet entered", tm_packet[1], 1);
        chk("R10 port0 idle", dut_mode(0), 5'h00);

        // R4 encodings on port 0 (state DISABLED)
        host_state[2:0] = 3'd2;
        step(1, A0, 8'h03); chk("R4 no enable", dut_mode(0), 5'h00);
        step(1, A0, 8'h86); chk("R4 two bits", dut_mode(0), 5'h00);
        step(1, A0, 8'h80); chk("R4 no mode bit", dut_mode(0), 5'h00);
        step(1, A0, 8'hF0);
        chk("R9 reserved ignored", tm_force_sof[0], 1);
        chk("R9 read 90h", rdata, 8'h90);

        // R2 decode
        step(1, 10'h165, 8'h00);
        chk("R2 neighbour write", tm_force_sof[0], 1);
        chk("R2 unmapped read", rdata, 8'h00);
        step(1, 10'h064, 8'h00);
        chk("R2 alias write", tm_force_sof[0], 1);
        step(1, A1, 8'h00);
        chk("R10 port1 exit only", idle_req, 2'b10);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] a;
            logic [7:0] d;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 4) ? A0 : (r < 8) ? A1 : 10'($urandom_range(0, 1023));
            r = $urandom_range(0, 9);
            if (r < 4) d = 8'h80 | (8'h01 << $urandom_range(0, 4)) | 8'($urandom_range(0, 3) << 5);
            else if (r < 6) d = 8'h00;
            else d = 8'($urandom_range(0, 255));
            host_state  = 6'($urandom_range(0, 63));
            chan_go     = ($urandom_range(0, 3) == 0) ? 12'(1 << $urandom_range(0, 11)) : 12'h000;
            support_go  = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
            auto_cancel = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            step($urandom_range(0, 9) < 7, a, d);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule